// File: doc/BRIEF.md
# Shared ADC Trigger Sequencer

This block lets a set of trigger sources take turns on a single ADC. Each source can be fired by a hardware pulse or by a software strobe. Each source carries its own configuration:

- a priority;
- a start delay;
- an interval count;
- a chain length;
- per chain step, the ADC channel to convert, a spacing flag and an event enable;
- a choice of whether its step events go out as interrupt pulses or as DMA request pulses.

When a source is picked, the sequencer counts out the start delay. It then runs the chain, one conversion request at a time, over a start/channel/done/result handshake. Each result lands in a result slot owned by that source and that step.

Sources that fire while the ADC is busy wait in a one-deep pending latch. When the sequencer goes idle, the pending source with the largest priority value wins, and the lower index wins a tie. A chain in progress always runs to its end. A source that fires again while it is already pending loses that arrival and sets a sticky overflow flag.

Top module: `adc_trigger_sequencer`

## Requirements
- R1: An arrival on `hw_trig[t]` or `sw_trig[t]` (high in a cycle) makes source t run a chain of exactly `cfg_len` field + 1 conversions, where the field of source t is `cfg_len[t*3 +: 3]` (0 means 1 step, 7 means 8 steps).
- R2: With the sequencer idle and nothing else pending, the first `adc_start` of source t comes D+3 cycles after the arrival cycle, where D is `cfg_delay[t*16 +: 16]`.
- R3: When the spacing flag `cfg_b2b[t*8+s]` of step s is 1, the start of step s+1 comes in the cycle right after the `adc_done` of step s.
- R4: When that flag is 0, the start of step s+1 comes I+2 cycles after the `adc_done` of step s, where I is `cfg_interval[t*16 +: 16]`.
- R5: `adc_start` is a one-cycle pulse. No new start is issued while a conversion is outstanding. During the start, `adc_chan` equals `cfg_chan[(t*8+s)*4 +: 4]` of the current step.
- R6: The `adc_result` captured with the done of step s of source t appears in `result[(t*8+s)*12 +: 12]` in the cycle after done. No other slot changes.
- R7: A finished step whose enable `cfg_irq_en[t*8+s]` is 1 gives a one-cycle pulse in the cycle after done. The pulse is on `irq_pulse[t]` when `cfg_dma_sel[t]` is 0 and on `dma_req[t]` when it is 1. A step whose enable is 0 gives no pulse.
- R8: Among pending sources, the one with the largest `cfg_prio[t*3 +: 3]` runs next, and equal priorities go to the lower index.
- R9: A running chain is never interrupted by an arrival at any other source, whatever that source's priority.
- R10: An arrival at a source that is not pending is latched, even while its own chain runs. An arrival at a source that is already pending is dropped and sets `ovf_flag[t]`, which stays set until reset.
- R11: After reset, `adc_start`, `irq_pulse`, `dma_req`, `ovf_flag` and all result slots are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_trig | input | NUM_TRIG | Hardware trigger arrivals, one per source |
| sw_trig | input | NUM_TRIG | Software trigger strobes, one per source |
| cfg_prio | input | NUM_TRIG*PRIO_W | Priority per source |
| cfg_delay | input | NUM_TRIG*CNT_W | Start delay per source, in cycles |
| cfg_interval | input | NUM_TRIG*CNT_W | Interval between spaced steps, in cycles |
| cfg_len | input | NUM_TRIG*LEN_W | Chain length minus one per source |
| cfg_chan | input | NUM_TRIG*MAX_CHAIN*CH_W | ADC channel per step |
| cfg_b2b | input | NUM_TRIG*MAX_CHAIN | Back-to-back flag per step |
| cfg_irq_en | input | NUM_TRIG*MAX_CHAIN | Completion event enable per step |
| cfg_dma_sel | input | NUM_TRIG | Route events to DMA request instead of interrupt |
| adc_start | output | 1 | Conversion request pulse |
| adc_chan | output | CH_W | Channel to convert, valid with adc_start |
| adc_done | input | 1 | Conversion finished pulse |
| adc_result | input | RES_W | Conversion result, valid with adc_done |
| result | output | NUM_TRIG*MAX_CHAIN*RES_W | Result slot per source and step |
| irq_pulse | output | NUM_TRIG | Interrupt pulse per source |
| dma_req | output | NUM_TRIG | DMA request pulse per source |
| ovf_flag | output | NUM_TRIG | Sticky dropped-arrival flag per source |

## Verification
Random single-source chains vary length, delay, interval, per-step spacing, channels, event routing and ADC latency, and fire through either the hardware or the software input. These runs separate the start-delay count from the interval count and from the back-to-back path, and they show that each result lands in its own slot while the rest stay put. Simultaneous arrivals with distinct priorities and with equal priorities tell the value ordering apart from the index tie-break. An arrival at a high-priority source during a low-priority chain shows that the chain is not interrupted. Repeated arrivals at a running source separate the single latched rerun from the dropped arrival that raises the overflow flag.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DELAY = 3'd1,
    ST_START = 3'd2,
    ST_WAIT  = 3'd3,
    ST_GAP   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/tsq_rst_sync.sv
module tsq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/tsq_pending.sv
module tsq_pending #(
  parameter int NUM_TRIG = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] arrive,
  input  logic [NUM_TRIG-1:0] take,
  output logic [NUM_TRIG-1:0] pend_o,
  output logic [NUM_TRIG-1:0] ovf_o
);
  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_src
    logic pend_q, pend_d, ovf_q, ovf_d;

    always_comb begin
      pend_d = (pend_q & ~take[g]) | arrive[g];
      ovf_d  = ovf_q | (arrive[g] & pend_q & ~take[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        ovf_q  <= 1'b0;
      end else begin
        pend_q <= pend_d;
        ovf_q  <= ovf_d;
      end
    end

    assign pend_o[g] = pend_q;
    assign ovf_o[g]  = ovf_q;
  end
endmodule

// File: rtl/tsq_arbiter.sv
module tsq_arbiter #(
  parameter int NUM_TRIG = 5,
  parameter int PRIO_W   = 3,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic [NUM_TRIG-1:0]        pend,
  input  logic [NUM_TRIG*PRIO_W-1:0] prio,
  output logic                       any_o,
  output logic [IDX_W-1:0]           win_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    best  = '0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (pend[i] && (!any_o || (prio[i*PRIO_W +: PRIO_W] > best))) begin
        any_o = 1'b1;
        win_o = IDX_W'(i);
        best  = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/tsq_chain_fsm.sv
module tsq_chain_fsm
  import tsq_pkg::*;
#(
  parameter int NUM_TRIG  = 5,
  parameter int MAX_CHAIN = 8,
  parameter int CH_W      = 4,
  parameter int CNT_W     = 16,
  localparam int LEN_W    = (MAX_CHAIN > 1) ? $clog2(MAX_CHAIN) : 1,
  localparam int IDX_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1,
  localparam int SLOTS    = NUM_TRIG * MAX_CHAIN,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          any_pend,
  input  logic [IDX_W-1:0]              win_idx,
  input  logic [NUM_TRIG*CNT_W-1:0]     cfg_delay,
  input  logic [NUM_TRIG*CNT_W-1:0]     cfg_interval,
  input  logic [NUM_TRIG*LEN_W-1:0]     cfg_len,
  input  logic [SLOTS*CH_W-1:0]         cfg_chan,
  input  logic [SLOTS-1:0]              cfg_b2b,
  input  logic [SLOTS-1:0]              cfg_irq_en,
  input  logic [NUM_TRIG-1:0]           cfg_dma_sel,
  input  logic                          adc_done,
  output logic [NUM_TRIG-1:0]           take_o,
  output logic                          adc_start_o,
  output logic [CH_W-1:0]               adc_chan_o,
  output logic                          wr_en_o,
  output logic [SLOT_W-1:0]             wr_slot_o,
  output logic [NUM_TRIG-1:0]           irq_o,
  output logic [NUM_TRIG-1:0]           dma_o
);
  seq_state_e         state_q, state_d;
  logic [IDX_W-1:0]   cur_q, cur_d;
  logic [LEN_W-1:0]   step_q, step_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [NUM_TRIG-1:0] irq_q, irq_d, dma_q, dma_d;

  int                 cur_i, win_i, slot_i;
  logic [LEN_W-1:0]   len_cur;
  logic [CH_W-1:0]    chan_cur;
  logic [CNT_W-1:0]   intv_cur;
  logic               b2b_cur, ie_cur, dsel_cur;

  always_comb begin
    cur_i    = int'(cur_q);
    win_i    = int'(win_idx);
    slot_i   = cur_i * MAX_CHAIN + int'(step_q);
    len_cur  = cfg_len[cur_i*LEN_W +: LEN_W];
    intv_cur = cfg_interval[cur_i*CNT_W +: CNT_W];
    chan_cur = cfg_chan[slot_i*CH_W +: CH_W];
    b2b_cur  = cfg_b2b[slot_i];
    ie_cur   = cfg_irq_en[slot_i];
    dsel_cur = cfg_dma_sel[cur_i];
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    step_d  = step_q;
    cnt_d   = cnt_q;
    take_o  = '0;
    wr_en_o = 1'b0;
    irq_d   = '0;
    dma_d   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (any_pend) begin
          for (int i = 0; i < NUM_TRIG; i++) take_o[i] = (i == win_i);
          cur_d   = win_idx;
          step_d  = '0;
          cnt_d   = cfg_delay[win_i*CNT_W +: CNT_W];
          state_d = ST_DELAY;
        end
      end
      ST_DELAY, ST_GAP: begin
        if (cnt_q == '0) state_d = ST_START;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      ST_START: state_d = ST_WAIT;
      ST_WAIT: begin
        if (adc_done) begin
          wr_en_o = 1'b1;
          for (int i = 0; i < NUM_TRIG; i++) begin
            irq_d[i] = ie_cur && !dsel_cur && (i == cur_i);
            dma_d[i] = ie_cur &&  dsel_cur && (i == cur_i);
          end
          if (step_q == len_cur) begin
            state_d = ST_IDLE;
          end else begin
            step_d = step_q + LEN_W'(1);
            if (b2b_cur) begin
              state_d = ST_START;
            end else begin
              cnt_d   = intv_cur;
              state_d = ST_GAP;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      step_q  <= '0;
      cnt_q   <= '0;
      irq_q   <= '0;
      dma_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      step_q  <= step_d;
      cnt_q   <= cnt_d;
      irq_q   <= irq_d;
      dma_q   <= dma_d;
    end
  end

  assign adc_start_o = (state_q == ST_START);
  assign adc_chan_o  = adc_start_o ? chan_cur : '0;
  assign wr_slot_o   = SLOT_W'(slot_i);
  assign irq_o       = irq_q;
  assign dma_o       = dma_q;
endmodule

// File: rtl/tsq_result_bank.sv
module tsq_result_bank #(
  parameter int SLOTS  = 40,
  parameter int RES_W  = 12,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SLOT_W-1:0]      wr_slot,
  input  logic [RES_W-1:0]       wr_data,
  output logic [SLOTS*RES_W-1:0] rd_flat
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic             load_en;
    logic [RES_W-1:0] data_q;

    assign load_en = wr_en && (wr_slot == SLOT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (load_en) data_q <= wr_data;
    end

    assign rd_flat[g*RES_W +: RES_W] = data_q;
  end
endmodule

// File: rtl/adc_trigger_sequencer.sv
module adc_trigger_sequencer #(
  parameter int NUM_TRIG  = 5,
  parameter int MAX_CHAIN = 8,
  parameter int CH_W      = 4,
  parameter int RES_W     = 12,
  parameter int CNT_W     = 16,
  parameter int PRIO_W    = 3,
  localparam int LEN_W    = (MAX_CHAIN > 1) ? $clog2(MAX_CHAIN) : 1,
  localparam int IDX_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1,
  localparam int SLOTS    = NUM_TRIG * MAX_CHAIN,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_TRIG-1:0]          hw_trig,
  input  logic [NUM_TRIG-1:0]          sw_trig,
  input  logic [NUM_TRIG*PRIO_W-1:0]   cfg_prio,
  input  logic [NUM_TRIG*CNT_W-1:0]    cfg_delay,
  input  logic [NUM_TRIG*CNT_W-1:0]    cfg_interval,
  input  logic [NUM_TRIG*LEN_W-1:0]    cfg_len,
  input  logic [SLOTS*CH_W-1:0]        cfg_chan,
  input  logic [SLOTS-1:0]             cfg_b2b,
  input  logic [SLOTS-1:0]             cfg_irq_en,
  input  logic [NUM_TRIG-1:0]          cfg_dma_sel,
  output logic                         adc_start,
  output logic [CH_W-1:0]              adc_chan,
  input  logic                         adc_done,
  input  logic [RES_W-1:0]             adc_result,
  output logic [SLOTS*RES_W-1:0]       result,
  output logic [NUM_TRIG-1:0]          irq_pulse,
  output logic [NUM_TRIG-1:0]          dma_req,
  output logic [NUM_TRIG-1:0]          ovf_flag
);
  logic                rst_n_int;
  logic [NUM_TRIG-1:0] arrive, take, pend;
  logic                any_pend;
  logic [IDX_W-1:0]    win_idx;
  logic                wr_en;
  logic [SLOT_W-1:0]   wr_slot;

  assign arrive = hw_trig | sw_trig;

  tsq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  tsq_pending #(.NUM_TRIG(NUM_TRIG)) u_pending (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .arrive (arrive),
    .take   (take),
    .pend_o (pend),
    .ovf_o  (ovf_flag)
  );

  tsq_arbiter #(.NUM_TRIG(NUM_TRIG), .PRIO_W(PRIO_W)) u_arbiter (
    .pend  (pend),
    .prio  (cfg_prio),
    .any_o (any_pend),
    .win_o (win_idx)
  );

  tsq_chain_fsm #(
    .NUM_TRIG(NUM_TRIG), .MAX_CHAIN(MAX_CHAIN), .CH_W(CH_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .any_pend     (any_pend),
    .win_idx      (win_idx),
    .cfg_delay    (cfg_delay),
    .cfg_interval (cfg_interval),
    .cfg_len      (cfg_len),
    .cfg_chan     (cfg_chan),
    .cfg_b2b      (cfg_b2b),
    .cfg_irq_en   (cfg_irq_en),
    .cfg_dma_sel  (cfg_dma_sel),
    .adc_done     (adc_done),
    .take_o       (take),
    .adc_start_o  (adc_start),
    .adc_chan_o   (adc_chan),
    .wr_en_o      (wr_en),
    .wr_slot_o    (wr_slot),
    .irq_o        (irq_pulse),
    .dma_o        (dma_req)
  );

  tsq_result_bank #(.SLOTS(SLOTS), .RES_W(RES_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_data (adc_result),
    .rd_flat (result)
  );
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
  parameter int NUM_TRIG = 5,
  parameter int RW_ALL   = 480
) (
  input logic                clk,
  input logic                rst_n,
  input logic                adc_start,
  input logic                adc_done,
  input logic [NUM_TRIG-1:0] irq_pulse,
  input logic [NUM_TRIG-1:0] dma_req,
  input logic [NUM_TRIG-1:0] ovf_flag,
  input logic [RW_ALL-1:0]   result
);
  logic conv_open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         conv_open_q <= 1'b0;
    else if (adc_start) conv_open_q <= 1'b1;
    else if (adc_done)  conv_open_q <= 1'b0;
  end

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  assert_one_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> !conv_open_q);

  assert_event_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_pulse | dma_req)) |-> $past(adc_done));

  assert_event_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse & dma_req) == '0);

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovf_flag) & ~ovf_flag) == '0);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(adc_done) |-> $stable(result));
endmodule

bind adc_trigger_sequencer tsq_checker #(
  .NUM_TRIG (NUM_TRIG),
  .RW_ALL   (SLOTS * RES_W)
) u_tsq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .adc_start (adc_start),
  .adc_done  (adc_done),
  .irq_pulse (irq_pulse),
  .dma_req   (dma_req),
  .ovf_flag  (ovf_flag),
  .result    (result)
);

// File: tb/adc_trigger_sequencer_bench.sv
`timescale 1ns/1ps
module adc_trigger_sequencer_bench;
  localparam int N = 5, M = 8, CHW = 4, RW = 12, CW = 16, PW = 3, LW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [N-1:0] hw_trig, sw_trig;
  logic [N*PW-1:0] cfg_prio;
  logic [N*CW-1:0] cfg_delay, cfg_interval;
  logic [N*LW-1:0] cfg_len;
  logic [N*M*CHW-1:0] cfg_chan;
  logic [N*M-1:0] cfg_b2b, cfg_irq_en;
  logic [N-1:0] cfg_dma_sel;
  logic adc_start, adc_done;
  logic [CHW-1:0] adc_chan;
  logic [RW-1:0] adc_result;
  logic [N*M*RW-1:0] result;
  logic [N-1:0] irq_pulse, dma_req, ovf_flag;

  int c_prio[N], c_delay[N], c_intv[N], c_len[N], c_dsel[N];
  int c_chan[N][M], c_b2b[N][M], c_ie[N][M];

  always_comb begin
    for (int t = 0; t < N; t++) begin
      cfg_prio[t*PW +: PW]     = PW'(c_prio[t]);
      cfg_delay[t*CW +: CW]    = CW'(c_delay[t]);
      cfg_interval[t*CW +: CW] = CW'(c_intv[t]);
      cfg_len[t*LW +: LW]      = LW'(c_len[t] - 1);
      cfg_dma_sel[t]           = (c_dsel[t] != 0);
      for (int s = 0; s < M; s++) begin
        cfg_chan[(t*M+s)*CHW +: CHW] = CHW'(c_chan[t][s]);
        cfg_b2b[t*M+s]    = (c_b2b[t][s] != 0);
        cfg_irq_en[t*M+s] = (c_ie[t][s] != 0);
      end
    end
  end

  adc_trigger_sequencer u_adc_trigger_sequencer (
    .clk(clk), .rst_n(rst_n), .hw_trig(hw_trig), .sw_trig(sw_trig),
    .cfg_prio(cfg_prio), .cfg_delay(cfg_delay), .cfg_interval(cfg_interval),
    .cfg_len(cfg_len), .cfg_chan(cfg_chan), .cfg_b2b(cfg_b2b),
    .cfg_irq_en(cfg_irq_en), .cfg_dma_sel(cfg_dma_sel),
    .adc_start(adc_start), .adc_chan(adc_chan), .adc_done(adc_done),
    .adc_result(adc_result), .result(result), .irq_pulse(irq_pulse),
    .dma_req(dma_req), .ovf_flag(ovf_flag)
  );

  int total = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // ADC model and monitor
  int lat_cfg = 2, dcount = 0, serial = 0;
  logic [CHW-1:0] open_ch;
  int n_st = 0, n_dn = 0;
  int st_cyc[64], st_ch[64], dn_cyc[64], dn_val[64];
  int irq_cnt[N], dma_cnt[N];

  always @(negedge clk) begin
    adc_done = 1'b0;
    if (dcount > 0) begin
      dcount = dcount - 1;
      if (dcount == 0) begin
        adc_done   = 1'b1;
        adc_result = {open_ch, serial[7:0]};
        if (n_dn < 64) begin dn_cyc[n_dn] = cyc; dn_val[n_dn] = int'(adc_result); end
        n_dn = n_dn + 1;
      end
    end
    if (adc_start === 1'b1) begin
      open_ch = adc_chan;
      serial  = serial + 1;
      dcount  = lat_cfg;
      if (n_st < 64) begin st_cyc[n_st] = cyc; st_ch[n_st] = int'(adc_chan); end
      n_st = n_st + 1;
    end
    for (int t = 0; t < N; t++) begin
      if (irq_pulse[t] === 1'b1) irq_cnt[t] = irq_cnt[t] + 1;
      if (dma_req[t] === 1'b1)   dma_cnt[t] = dma_cnt[t] + 1;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_st = 0; n_dn = 0;
    for (int t = 0; t < N; t++) begin irq_cnt[t] = 0; dma_cnt[t] = 0; end
  endtask

  int trig_cyc;
  task automatic fire(input logic [N-1:0] mask, input bit use_sw);
    @(negedge clk);
    trig_cyc = cyc;
    if (use_sw) sw_trig = mask; else hw_trig = mask;
    @(negedge clk);
    sw_trig = '0; hw_trig = '0;
  endtask

  task automatic wait_chain(input int n);
    for (int k = 0; k < 5000; k++) begin
      if (n_st >= n && n_dn >= n) break;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  function automatic int slot_val(input int t, input int s);
    return int'(result[(t*M+s)*RW +: RW]);
  endfunction

  function automatic int exp_gap(input int b2b, input int intv);
    return (b2b != 0) ? 1 : intv + 2;
  endfunction

  int exp_res[N][M];

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1ADC5EED));
    rst_n = 1'b0; hw_trig = '0; sw_trig = '0; adc_done = 1'b0; adc_result = '0;
    for (int t = 0; t < N; t++) begin
      c_prio[t] = 0; c_delay[t] = 0; c_intv[t] = 0; c_len[t] = 1; c_dsel[t] = 0;
      irq_cnt[t] = 0; dma_cnt[t] = 0;
      for (int s = 0; s < M; s++) begin
        c_chan[t][s] = 0; c_b2b[t][s] = 1; c_ie[t][s] = 0; exp_res[t][s] = 0;
      end
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 adc_start", adc_start, 0);
    chk("R11 irq_pulse", irq_pulse, 0);
    chk("R11 dma_req", dma_req, 0);
    chk("R11 ovf_flag", ovf_flag, 0);
    chk("R11 result", (result == '0) ? 0 : 1, 0);

    // random single-source chains: R1 R2 R3 R4 R5 R6 R7
    for (int it = 0; it < 30; it++) begin
      int t, ei, ed;
      t = int'($urandom % N);
      c_len[t]   = 1 + int'($urandom % M);
      c_delay[t] = int'($urandom % 21);
      c_intv[t]  = int'($urandom % 11);
      c_dsel[t]  = int'($urandom % 2);
      if (it == 0) c_len[t] = M;
      if (it == 1) c_len[t] = 1;
      for (int s = 0; s < M; s++) begin
        c_chan[t][s] = int'($urandom % 16);
        c_b2b[t][s]  = int'($urandom % 2);
        c_ie[t][s]   = int'($urandom % 2);
      end
      lat_cfg = 1 + int'($urandom % 4);
      clear_logs();
      fire(N'(1) << t, bit'($urandom % 2));
      wait_chain(c_len[t]);
      chk("R1 chain length", n_st, c_len[t]);
      chk("R2 start delay", st_cyc[0] - trig_cyc, c_delay[t] + 3);
      ei = 0; ed = 0;
      for (int s = 0; s < c_len[t] && s < n_dn; s++) begin
        chk("R5 channel", st_ch[s], c_chan[t][s]);
        if (s > 0) begin
          if (c_b2b[t][s-1] != 0) chk("R3 back-to-back gap", st_cyc[s] - dn_cyc[s-1], 1);
          else chk("R4 interval gap", st_cyc[s] - dn_cyc[s-1], exp_gap(0, c_intv[t]));
        end
        exp_res[t][s] = dn_val[s];
        if (c_ie[t][s] != 0) begin
          if (c_dsel[t] != 0) ed++; else ei++;
        end
      end
      for (int u = 0; u < N; u++) begin
        chk("R7 irq count", irq_cnt[u], (u == t) ? ei : 0);
        chk("R7 dma count", dma_cnt[u], (u == t) ? ed : 0);
        for (int s = 0; s < M; s++) chk("R6 result slot", slot_val(u, s), exp_res[u][s]);
      end
    end

    // directed: priority order R8
    lat_cfg = 2;
    for (int t = 0; t < N; t++) begin
      c_len[t] = 1; c_delay[t] = 0; c_chan[t][0] = t + 1; c_ie[t][0] = 0;
    end
    c_prio[0] = 1; c_prio[1] = 5; c_prio[2] = 3;
    clear_logs();
    fire(5'b00111, 1'b0);
    wait_chain(3);
    chk("R8 first by priority", st_ch[0], 2);
    chk("R8 second by priority", st_ch[1], 3);
    chk("R8 third by priority", st_ch[2], 1);

    // directed: tie goes to lower index R8
    c_prio[3] = 7; c_prio[4] = 7;
    clear_logs();
    fire(5'b11000, 1'b1);
    wait_chain(2);
    chk("R8 tie lower index first", st_ch[0], 4);
    chk("R8 tie higher index second", st_ch[1], 5);

    // directed: no preemption R9
    c_prio[0] = 0; c_len[0] = 4; lat_cfg = 3;
    for (int s = 0; s < 4; s++) begin c_chan[0][s] = 1; c_b2b[0][s] = 1; end
    clear_logs();
    fire(5'b00001, 1'b0);
    while (n_st < 1) @(negedge clk);
    fire(5'b10000, 1'b0);
    wait_chain(5);
    for (int s = 0; s < 4; s++) chk("R9 running chain kept", st_ch[s], 1);
    chk("R9 high priority after", st_ch[4], 5);
    chk("R10 no overflow yet", ovf_flag, 0);

    // directed: latch once, drop and overflow R10
    c_len[2] = 2; c_chan[2][0] = 3; c_chan[2][1] = 3; c_b2b[2][0] = 1; lat_cfg = 4;
    clear_logs();
    fire(5'b00100, 1'b1);
    while (n_st < 1) @(negedge clk);
    fire(5'b00100, 1'b0);
    fire(5'b00100, 1'b0);
    wait_chain(4);
    repeat (40) @(negedge clk);
    chk("R10 one latched rerun", n_st, 4);
    chk("R10 overflow flag", ovf_flag, 5'b00100);
    repeat (10) @(negedge clk);
    chk("R10 overflow sticky", ovf_flag, 5'b00100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule